// File: doc/BRIEF.md
# Linear CCD Line Timing Sequencer

This block produces the logic-level clock and gate sequence that drives a resistive-gate linear CCD with an electronic shutter. A pulse on `lineStart` begins a line. The block first raises the resistive-gate slope select for a programmable lead time. It then opens the transfer gate, raises horizontal phase 1 while the transfer gate is still high, and drops the transfer gate. After that, two-phase horizontal clocking shifts out a fixed number of pixels: leading blanks, active pixels and trailing blanks. Horizontal clocking does not stop when the line ends. Dummy pixels keep draining the register until the next accepted `lineStart`.

The shutter gate controls integration. It is high (shutter closed, charge dumped) from the end of the transfer pulse until the start of a programmed pixel position. At that point it goes low (shutter open), so the integration window ends at the next transfer-gate fall. Two slope modes are available. In the low-dark-current mode the slope select stays low during integration and is raised only around the transfer. In the other mode it stays high permanently.

Every pixel carries a reset pulse, a clamp strobe and a sample strobe for external correlated double sampling. The block also gives a pixel index with a valid flag for active pixels. It raises a warning when the programmed shutter-open point lands inside the active readout window. All widths and positions are sampled once, when a line is accepted.

Top module: `ccd_line_seq`

## Requirements
- R1: While in reset and afterwards until the first line, every output is low except `slopeSel`, which is high.
- R2: `lineStart` is accepted only when `busy` is low. A pulse while busy is ignored, so each line produces exactly one `xferGate` pulse.
- R3: `xferGate` stays high for `cfgTgWidth` cycles. `hClk1` rises `cfgHalfPeriod` cycles before `xferGate` falls and is still high in the cycle it falls.
- R4: After `xferGate` falls, exactly PRE_PIX+ACT_PIX+POST_PIX pixels (one `hClk2` rise each) occur while `busy` is high, and then `busy` falls. Dummy pixels continue after that. `hClk2` stays low during the lead and transfer phases.
- R5: With `cfgMpp` low, `slopeSel` stays high. With `cfgMpp` high, it rises `cfgSlopeLead` cycles before `xferGate` rises and falls in the same cycle as `xferGate`.
- R6: Pixels are numbered from 0, starting at the first pixel after `xferGate` falls. `pixValid` is high exactly for pixels PRE_PIX to PRE_PIX+ACT_PIX-1, and `pixIndex` equals the pixel number minus PRE_PIX.
- R7: With `cfgShutterEn` low, `shutterGate` stays low. With it high, `shutterGate` rises in the cycle `xferGate` falls and falls together with the `cfgOpenAt`-th `hClk1` rise after that. A `cfgOpenAt` of 0 leaves the gate low.
- R8: Each pixel lasts 2·`cfgHalfPeriod` cycles. `hClk1` is high for the first half and `hClk2` for the second half, the two are never high together, and `sumGate` equals `hClk2`.
- R9: `resetPulse` is high for `cfgRgWidth` cycles from the start of each pixel. `clampStb` is high for the one cycle in which `resetPulse` falls. `sampleStb` is high in the last cycle of each `hClk2` high phase.
- R10: On an accepted line, `shutterWarn` becomes high exactly when the shutter is enabled and `cfgOpenAt` lies in [PRE_PIX, PRE_PIX+ACT_PIX).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | Begin a line (ignored while busy) |
| cfgMpp | input | 1 | 1: slope only around the transfer; 0: slope always on |
| cfgShutterEn | input | 1 | Enable electronic shutter |
| cfgTgWidth | input | 8 | Transfer-gate high width in cycles |
| cfgHalfPeriod | input | 8 | Horizontal half period in cycles (min 2) |
| cfgRgWidth | input | 8 | Reset pulse width in cycles (below half period) |
| cfgSlopeLead | input | 8 | Slope lead before the transfer gate, cycles |
| cfgOpenAt | input | 16 | Pixel number after transfer at which the shutter opens |
| shutterGate | output | 1 | All-reset gate drive, high = shutter closed |
| xferGate | output | 1 | Transfer gate drive |
| slopeSel | output | 1 | Resistive-gate slope select |
| hClk1 | output | 1 | Horizontal phase 1 |
| hClk2 | output | 1 | Horizontal phase 2 |
| sumGate | output | 1 | Summing gate |
| resetPulse | output | 1 | Output-node reset gate |
| clampStb | output | 1 | CDS clamp strobe |
| sampleStb | output | 1 | CDS sample strobe |
| busy | output | 1 | Line in lead, transfer or normal readout |
| pixValid | output | 1 | Current pixel is active |
| pixIndex | output | IW | Active pixel index |
| shutterWarn | output | 1 | Shutter point falls inside the active window |

## Verification
The bench builds the block with PRE_PIX=3, ACT_PIX=8 and POST_PIX=2, so a line is 13 pixels long and half periods of 2 to 4 cycles keep each line to a few hundred cycles. At these sizes the edges of the active window, shutter points placed before it, inside it, on its last pixel and out in the dummy region, and a shutter that never closes can all be reached in one run. The sequences also cover mode switches between consecutive lines and line requests issued mid-readout.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
  parameter int CNT_W = 8;
  parameter int POS_W = 16;

  typedef struct packed {
    logic             mpp;
    logic             shutEn;
    logic [CNT_W-1:0] tgW;
    logic [CNT_W-1:0] halfPer;
    logic [CNT_W-1:0] rgW;
    logic [CNT_W-1:0] lead;
    logic [POS_W-1:0] openAt;
  } seq_cfg_t;

  typedef struct packed {
    logic hRun;
    logic xferOn;
    logic p1Force;
    logic slopeOn;
    logic shutClose;
    logic busyOn;
    logic activeOn;
  } seq_strobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_XFER, S_READ, S_DUMMY
  } seq_state_t;
endpackage

// File: rtl/ccdseq_ctrl.sv
module ccdseq_ctrl
  import ccdseq_pkg::*;
#(
  parameter int PRE_PIX  = 70,
  parameter int ACT_PIX  = 2048,
  parameter int POST_PIX = 10,
  parameter int IW       = 11
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  seq_cfg_t    cfgIn,
  input  logic        pixEnd,
  output seq_cfg_t    cfgQ,
  output seq_strobe_t stb,
  output logic [IW-1:0] pixOff,
  output logic        warnQ
);
  localparam int LINE = PRE_PIX + ACT_PIX + POST_PIX;
  localparam logic [POS_W-1:0] LAST_PIX = POS_W'(LINE - 1);
  localparam logic [POS_W-1:0] WIN_LO   = POS_W'(PRE_PIX);
  localparam logic [POS_W-1:0] WIN_HI   = POS_W'(PRE_PIX + ACT_PIX);
  localparam logic [POS_W-1:0] PC_MAX   = '1;
  localparam logic [CNT_W-1:0] ONE_C    = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO_C    = CNT_W'(2);
  localparam logic [CNT_W-1:0] HP_MAX   = CNT_W'((1 << (CNT_W - 1)) - 1);

  seq_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic [POS_W-1:0] pc;
  seq_cfg_t         cfgSan;
  logic             accept;
  logic             warnNext;

  // Sanitise the requested widths so the phase ordering always holds
  always_comb begin
    cfgSan = cfgIn;
    if (cfgIn.halfPer < TWO_C)       cfgSan.halfPer = TWO_C;
    else if (cfgIn.halfPer > HP_MAX) cfgSan.halfPer = HP_MAX;
    if (cfgIn.rgW == '0)                   cfgSan.rgW = ONE_C;
    else if (cfgIn.rgW >= cfgSan.halfPer)  cfgSan.rgW = cfgSan.halfPer - ONE_C;
    if (cfgIn.tgW <= cfgSan.halfPer)       cfgSan.tgW = cfgSan.halfPer + ONE_C;
    if (cfgIn.lead == '0)                  cfgSan.lead = ONE_C;
  end

  assign accept   = lineStart && (state == S_IDLE || state == S_DUMMY);
  assign warnNext = cfgIn.shutEn && (cfgIn.openAt >= WIN_LO) && (cfgIn.openAt < WIN_HI);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      pc    <= '0;
      cfgQ  <= '0;
      warnQ <= 1'b0;
    end else if (accept) begin
      cfgQ  <= cfgSan;
      warnQ <= warnNext;
      state <= S_LEAD;
      cnt   <= '0;
    end else begin
      case (state)
        S_LEAD: begin
          if (cnt == cfgQ.lead - ONE_C) begin
            state <= S_XFER;
            cnt   <= '0;
          end else begin
            cnt <= cnt + ONE_C;
          end
        end
        S_XFER: begin
          if (cnt == cfgQ.tgW - ONE_C) begin
            state <= S_READ;
            cnt   <= '0;
            pc    <= '0;
          end else begin
            cnt <= cnt + ONE_C;
          end
        end
        S_READ: begin
          if (pixEnd) begin
            pc <= pc + POS_W'(1);
            if (pc == LAST_PIX) state <= S_DUMMY;
          end
        end
        S_DUMMY: begin
          if (pixEnd && pc != PC_MAX) pc <= pc + POS_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.hRun      = (state == S_READ) || (state == S_DUMMY);
    stb.xferOn    = (state == S_XFER);
    stb.p1Force   = (state == S_XFER) && (cnt >= cfgQ.tgW - cfgQ.halfPer);
    stb.slopeOn   = !cfgQ.mpp || (state == S_LEAD) || (state == S_XFER);
    stb.shutClose = cfgQ.shutEn && stb.hRun && (pc < cfgQ.openAt);
    stb.busyOn    = (state == S_LEAD) || (state == S_XFER) || (state == S_READ);
    stb.activeOn  = (state == S_READ) && (pc >= WIN_LO) && (pc < WIN_HI);
  end

  assign pixOff = IW'(pc - WIN_LO);

  // R2: a request during readout never restarts the line
  p_ignore_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_READ && lineStart) |=> (state != S_LEAD));

  // R4: the dummy region is only reached after a full line of pixels
  p_full_line_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DUMMY) |-> (pc >= POS_W'(LINE)));
endmodule

// File: rtl/ccdseq_drive.sv
module ccdseq_drive
  import ccdseq_pkg::*;
#(
  parameter int IW = 11
) (
  input  logic             clk,
  input  logic             rstN,
  input  seq_strobe_t      stb,
  input  logic [CNT_W-1:0] halfPer,
  input  logic [CNT_W-1:0] rgW,
  input  logic [IW-1:0]    pixOff,
  output logic             pixEnd,
  output logic             shutQ,
  output logic             tgQ,
  output logic             slopeQ,
  output logic             p1Q,
  output logic             p2Q,
  output logic             sgQ,
  output logic             rgQ,
  output logic             clampQ,
  output logic             sampleQ,
  output logic             busyQ,
  output logic             validQ,
  output logic [IW-1:0]    idxQ
);
  logic [CNT_W:0] c;
  logic [CNT_W:0] perLast;
  logic [CNT_W:0] hpX;
  logic [CNT_W:0] rgX;
  logic           p1N, p2N, rgN, clampN;

  assign hpX     = {1'b0, halfPer};
  assign rgX     = {1'b0, rgW};
  assign perLast = {halfPer, 1'b0} - {{CNT_W{1'b0}}, 1'b1};
  assign pixEnd  = stb.hRun && (c == perLast);

  always_ff @(posedge clk) begin
    if (!rstN || !stb.hRun || pixEnd) c <= '0;
    else                              c <= c + {{CNT_W{1'b0}}, 1'b1};
  end

  always_comb begin
    p1N    = stb.p1Force || (stb.hRun && c < hpX);
    p2N    = stb.hRun && (c >= hpX);
    rgN    = stb.hRun && (c < rgX);
    clampN = stb.hRun && (c == rgX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shutQ   <= 1'b0;
      tgQ     <= 1'b0;
      slopeQ  <= 1'b1;
      p1Q     <= 1'b0;
      p2Q     <= 1'b0;
      sgQ     <= 1'b0;
      rgQ     <= 1'b0;
      clampQ  <= 1'b0;
      sampleQ <= 1'b0;
      busyQ   <= 1'b0;
      validQ  <= 1'b0;
      idxQ    <= '0;
    end else begin
      shutQ   <= stb.shutClose;
      tgQ     <= stb.xferOn;
      slopeQ  <= stb.slopeOn;
      p1Q     <= p1N;
      p2Q     <= p2N;
      sgQ     <= p2N;
      rgQ     <= rgN;
      clampQ  <= clampN;
      sampleQ <= pixEnd;
      busyQ   <= stb.busyOn;
      validQ  <= stb.activeOn;
      idxQ    <= stb.activeOn ? pixOff : '0;
    end
  end

  // R3: phase 1 already high when the transfer gate drops
  p_p1_at_xfer_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgQ) |-> p1Q);
  // R5: slope present whenever the transfer gate opens
  p_slope_before_xfer_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgQ) |-> slopeQ);
  // R5: slope only ever drops together with the transfer gate
  p_slope_drop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(slopeQ) |-> $fell(tgQ));
  // R8: horizontal phases never overlap
  p_phase_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({p1Q, p2Q}));
  // R9: clamp follows the end of the reset pulse
  p_clamp_after_reset_r9: assert property (@(posedge clk) disable iff (!rstN)
    clampQ |-> (!rgQ && $past(rgQ)));
  // R9: sample taken while the summing gate holds charge
  p_sample_in_sum_r9: assert property (@(posedge clk) disable iff (!rstN)
    sampleQ |-> (p2Q && sgQ));
  // R6: active pixels only appear within a busy line
  p_valid_in_line_r6: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> busyQ);
endmodule

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccdseq_pkg::*;
#(
  parameter int PRE_PIX  = 70,
  parameter int ACT_PIX  = 2048,
  parameter int POST_PIX = 10,
  parameter int IW       = (ACT_PIX > 1) ? $clog2(ACT_PIX) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStart,
  input  logic             cfgMpp,
  input  logic             cfgShutterEn,
  input  logic [CNT_W-1:0] cfgTgWidth,
  input  logic [CNT_W-1:0] cfgHalfPeriod,
  input  logic [CNT_W-1:0] cfgRgWidth,
  input  logic [CNT_W-1:0] cfgSlopeLead,
  input  logic [POS_W-1:0] cfgOpenAt,
  output logic             shutterGate,
  output logic             xferGate,
  output logic             slopeSel,
  output logic             hClk1,
  output logic             hClk2,
  output logic             sumGate,
  output logic             resetPulse,
  output logic             clampStb,
  output logic             sampleStb,
  output logic             busy,
  output logic             pixValid,
  output logic [IW-1:0]    pixIndex,
  output logic             shutterWarn
);
  seq_cfg_t    cfgIn;
  seq_cfg_t    cfgQ;
  seq_strobe_t stb;
  logic [IW-1:0] pixOff;
  logic        pixEnd;

  always_comb begin
    cfgIn.mpp     = cfgMpp;
    cfgIn.shutEn  = cfgShutterEn;
    cfgIn.tgW     = cfgTgWidth;
    cfgIn.halfPer = cfgHalfPeriod;
    cfgIn.rgW     = cfgRgWidth;
    cfgIn.lead    = cfgSlopeLead;
    cfgIn.openAt  = cfgOpenAt;
  end

  ccdseq_ctrl #(
    .PRE_PIX(PRE_PIX), .ACT_PIX(ACT_PIX), .POST_PIX(POST_PIX), .IW(IW)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .cfgIn(cfgIn),
    .pixEnd(pixEnd), .cfgQ(cfgQ), .stb(stb), .pixOff(pixOff),
    .warnQ(shutterWarn)
  );

  ccdseq_drive #(.IW(IW)) u_drive (
    .clk(clk), .rstN(rstN), .stb(stb), .halfPer(cfgQ.halfPer),
    .rgW(cfgQ.rgW), .pixOff(pixOff), .pixEnd(pixEnd),
    .shutQ(shutterGate), .tgQ(xferGate), .slopeQ(slopeSel),
    .p1Q(hClk1), .p2Q(hClk2), .sgQ(sumGate), .rgQ(resetPulse),
    .clampQ(clampStb), .sampleQ(sampleStb), .busyQ(busy),
    .validQ(pixValid), .idxQ(pixIndex)
  );
endmodule

// File: tb/tb_ccd_line_seq.sv
module tb_ccd_line_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PRE  = 3;
  localparam int ACT  = 8;
  localparam int POST = 2;
  localparam int LINE = PRE + ACT + POST;
  localparam int IW   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0;
  logic cfgMpp = 1'b0, cfgShutterEn = 1'b0;
  logic [7:0] cfgTgWidth = 8'd4, cfgHalfPeriod = 8'd2, cfgRgWidth = 8'd1, cfgSlopeLead = 8'd1;
  logic [15:0] cfgOpenAt = 16'd0;
  logic shutterGate, xferGate, slopeSel, hClk1, hClk2, sumGate, resetPulse;
  logic clampStb, sampleStb, busy, pixValid, shutterWarn;
  logic [IW-1:0] pixIndex;

  int nChecks = 0;
  int nFail = 0;
  bit prevMpp = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ccd_line_seq #(.PRE_PIX(PRE), .ACT_PIX(ACT), .POST_PIX(POST), .IW(IW)) dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .cfgMpp(cfgMpp),
    .cfgShutterEn(cfgShutterEn), .cfgTgWidth(cfgTgWidth),
    .cfgHalfPeriod(cfgHalfPeriod), .cfgRgWidth(cfgRgWidth),
    .cfgSlopeLead(cfgSlopeLead), .cfgOpenAt(cfgOpenAt),
    .shutterGate(shutterGate), .xferGate(xferGate), .slopeSel(slopeSel),
    .hClk1(hClk1), .hClk2(hClk2), .sumGate(sumGate), .resetPulse(resetPulse),
    .clampStb(clampStb), .sampleStb(sampleStb), .busy(busy),
    .pixValid(pixValid), .pixIndex(pixIndex), .shutterWarn(shutterWarn)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit inWin(input int k);
    return (k >= PRE) && (k < PRE + ACT);
  endfunction

  function automatic bit expWarn(input bit shut, input int openAt);
    return shut && inWin(openAt);
  endfunction

  function automatic int idleOutputs();
    return {shutterGate, xferGate, hClk1, hClk2, sumGate, resetPulse,
            clampStb, sampleStb, busy, pixValid, shutterWarn};
  endfunction

  task automatic runLine(input bit mpp, input bit shut, input int tgW, input int hp,
                         input int rgW, input int lead, input int openAt, input bit poke);
    int total;
    int tgRiseT = -1, tgFallT = -1, lastP1Rise = -1, slopeRiseT = -1, slopeFallT = -1;
    int tgRises = 0, p1Rises = 0, p2Rises = 0, busyPix = -1, busyCnt = 0;
    int validCnt = 0, validErr = 0, sgErr = 0, rgErr = 0, clampErr = 0, smpErr = 0;
    int p2Err = 0, stopErr = 0, rgStart = 0, p2RiseT = 0;
    int shutRiseT = -1, shutFallP1 = -1, shutHigh = 0;
    bit afterFall = 0, p1AtFall = 0, slopeLow = 0, shutFell = 0;
    bit pTg, pP1, pP2, pRg, pSl, pSh, pBusy, pSmp;
    @(negedge clk);
    cfgMpp = mpp; cfgShutterEn = shut; cfgTgWidth = 8'(tgW); cfgHalfPeriod = 8'(hp);
    cfgRgWidth = 8'(rgW); cfgSlopeLead = 8'(lead); cfgOpenAt = 16'(openAt);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    pTg = xferGate; pP1 = hClk1; pP2 = hClk2; pRg = resetPulse; pSl = slopeSel;
    pSh = shutterGate; pBusy = busy; pSmp = sampleStb;
    total = lead + tgW + (LINE + openAt + 3) * 2 * hp + 8;
    for (int t = 1; t <= total; t++) begin
      @(negedge clk);
      if (poke && t == lead + tgW + 5) lineStart = 1'b1;
      else lineStart = 1'b0;
      if (t >= 2 && !afterFall && hClk2) stopErr++;
      if (!pTg && xferGate) begin tgRiseT = t; tgRises++; end
      if (pTg && !xferGate) begin tgFallT = t; afterFall = 1; p1AtFall = hClk1; end
      if (!pP1 && hClk1) begin
        if (!afterFall) lastP1Rise = t; else p1Rises++;
      end
      if (!pSl && slopeSel && !afterFall) slopeRiseT = t;
      if (pSl && !slopeSel) slopeFallT = t;
      if (!slopeSel) slopeLow = 1;
      if (sumGate != hClk2) sgErr++;
      if (afterFall) begin
        if (!pP2 && hClk2) begin
          if (busy) begin
            if (pixValid != inWin(p2Rises)) validErr++;
            if (pixValid) begin
              validCnt++;
              if (int'(pixIndex) != p2Rises - PRE) validErr++;
            end
            busyCnt++;
          end
          p2Rises++;
          p2RiseT = t;
        end
        if (pP2 && !hClk2) begin
          if (t - p2RiseT != hp) p2Err++;
          if (!pSmp) smpErr++;
        end
        if (!pRg && resetPulse) rgStart = t;
        if (pRg && !resetPulse) begin
          if (t - rgStart != rgW) rgErr++;
          if (!clampStb) clampErr++;
        end
        if (clampStb && !(pRg && !resetPulse)) clampErr++;
        if (sampleStb && !hClk2) smpErr++;
        if (pBusy && !busy) busyPix = busyCnt;
      end
      if (shutterGate) shutHigh++;
      if (!pSh && shutterGate) shutRiseT = t;
      if (pSh && !shutterGate) begin shutFell = 1; shutFallP1 = p1Rises; end
      pTg = xferGate; pP1 = hClk1; pP2 = hClk2; pRg = resetPulse; pSl = slopeSel;
      pSh = shutterGate; pBusy = busy; pSmp = sampleStb;
    end
    lineStart = 1'b0;
    // R2: one transfer pulse per accepted line
    check(tgRises == 1, "R2 transfer pulses per line", tgRises, 1);
    // R3: transfer width and phase-1 overlap
    check(tgFallT - tgRiseT == tgW, "R3 xferGate width", tgFallT - tgRiseT, tgW);
    check(tgFallT - lastP1Rise == hp && p1AtFall, "R3 hClk1 lead before xfer fall",
          tgFallT - lastP1Rise, hp);
    // R4: pixels during busy, dummy continues, clocks stopped before transfer
    check(busyPix == LINE, "R4 pixels while busy", busyPix, LINE);
    check(p2Rises > LINE && stopErr == 0, "R4 dummy clocking / stop", p2Rises, LINE + 1);
    // R5: slope select
    if (mpp) begin
      if (prevMpp)
        check(tgRiseT - slopeRiseT == lead, "R5 slope lead", tgRiseT - slopeRiseT, lead);
      check(slopeFallT == tgFallT && !slopeSel, "R5 slope fall with xfer", slopeFallT, tgFallT);
    end else begin
      check(!slopeLow, "R5 slope held in non-MPP", int'(slopeLow), 0);
    end
    // R6: active window and index
    check(validCnt == ACT && validErr == 0, "R6 valid pixels", validCnt, ACT);
    // R7: shutter
    if (!shut || openAt == 0) begin
      check(shutHigh == 0, "R7 shutter stays open", shutHigh, 0);
    end else begin
      check(shutRiseT == tgFallT, "R7 shutter closes at xfer fall", shutRiseT, tgFallT);
      check(shutFell && shutFallP1 == openAt, "R7 shutter open point", shutFallP1, openAt);
    end
    // R8: phase shape
    check(sgErr == 0 && p2Err == 0, "R8 phase widths / sumGate", sgErr + p2Err, 0);
    // R9: CDS strobes
    check(rgErr == 0 && clampErr == 0 && smpErr == 0, "R9 reset/clamp/sample",
          rgErr + clampErr + smpErr, 0);
    // R10: warning flag
    check(shutterWarn == expWarn(shut, openAt), "R10 shutter warning",
          int'(shutterWarn), int'(expWarn(shut, openAt)));
    prevMpp = mpp;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    // R1: values held in reset
    check(idleOutputs() == 0 && slopeSel, "R1 outputs in reset", idleOutputs(), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(idleOutputs() == 0 && slopeSel, "R1 outputs idle after reset", idleOutputs(), 0);
    // directed corners
    runLine(0, 0, 5, 2, 1, 2, 0, 0);
    runLine(1, 1, 6, 3, 2, 3, 5, 1);
    runLine(1, 1, 7, 4, 3, 4, LINE + 2, 0);
    runLine(0, 1, 4, 2, 1, 1, 0, 0);
    runLine(1, 1, 5, 2, 1, 2, PRE - 1, 0);
    runLine(1, 1, 5, 2, 1, 1, PRE + ACT - 1, 1);
    runLine(0, 1, 6, 3, 1, 2, PRE + ACT, 0);
    runLine(1, 1, 4, 3, 2, 5, PRE, 0);
    // randomized lines
    for (int i = 0; i < 10; i++) begin
      int hp, rg, tg, ld, oa;
      hp = 2 + int'($urandom % 3);
      rg = 1 + int'($urandom % (hp - 1));
      tg = hp + 1 + int'($urandom % 5);
      ld = 1 + int'($urandom % 5);
      oa = int'($urandom % (LINE + 4));
      runLine(bit'($urandom % 2), bit'($urandom % 2), tg, hp, rg, ld, oa, bit'($urandom % 2));
    end
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule